// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter with one control/status register. The same counter can run as a periodic interval timer or as a system watchdog. Software reaches both registers over a small register bus. Address 0 selects the control/status register and address 1 selects the counter. A bank of eight prescaled clock-enable inputs sets the counting rate, and a 3-bit field in the control register picks which of the eight is used.

When the counter steps from 0xFF to 0x00, the overflow flag is set. In interval mode the overflow also raises a one-cycle interrupt request and counting carries on. In watchdog mode the overflow raises either a one-cycle NMI request or an internal reset request. The reset request is held high for a fixed number of cycles, and when that pulse ends the block returns its own registers to their reset values. The overflow flag clears only after a handshake: software first reads the control register while the flag is set, then writes 0 to the flag bit. Turning the timer off also clears the flag.

Control register layout: bit 7 overflow flag, bit 6 mode (0 interval, 1 watchdog), bit 5 enable, bit 4 reserved (reads 1), bit 3 watchdog action (0 NMI, 1 reset), bits 2..0 clock-enable select.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset the control register reads 0x10, the counter reads 0x00, and all three request outputs are low.
- R2: While bit 5 is 1, the counter advances by one on every cycle in which tick_en[bits 2..0] is high. A counter write takes precedence over the increment.
- R3: While bit 5 is 0, the counter is held at 0x00 and counter writes are ignored. A control write that clears bit 5 forces the counter to 0x00 at that edge.
- R4: A step of the counter from 0xFF to 0x00 sets bit 7 in both modes. The flag becomes visible in the cycle after the edge at which the counter wraps.
- R5: A control write with bit 7 = 0 clears the flag only when an earlier bus read of the control register saw the flag at 1. Writing 1 to bit 7 leaves it unchanged, and an overflow in the same cycle as a clear leaves the flag set.
- R6: A control write with bit 5 = 0 clears the flag whether or not it was read before.
- R7: In interval mode (bit 6 = 0) each overflow produces irq_interval high for exactly one cycle, at the same time as the flag appears, and the counter continues from 0x00.
- R8: In watchdog mode with bit 3 = 0, each overflow produces nmi_req high for exactly one cycle. irq_interval stays low and reset_req is not raised.
- R9: In watchdog mode with bit 3 = 1, an overflow raises reset_req for exactly RST_CYCLES consecutive cycles. In the cycle after the pulse ends, the control register reads 0x10 and the counter reads 0x00.
- R10: Bit 4 of the control register reads 1 whatever value is written to it.
- R11: A counter write while bit 5 is 1 loads the written value, which reads back in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when selected |
| bus_rd | input | 1 | Read when selected (arms the flag clear) |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| tick_en | input | 8 | Prescaled clock enables, one per select code |
| irq_interval | output | 1 | One-cycle interval interrupt request |
| nmi_req | output | 1 | One-cycle watchdog NMI request |
| reset_req | output | 1 | Internal reset request pulse |

## Verification
The assertions assume that a bus access never has read and write strobes active together. The single-cycle pulse checks also rely on the counter never needing a second overflow in the cycle right after one, which holds because a wrap always leaves the counter at 0x00. The stimulus drives either rd or wr on each access, never both, and presets the counter near 0xFF only through ordinary bus writes. A behavioural model in the bench is compared with every output on every clock. Its tick pattern drives each enable at a different rate, so the chosen select code affects the result.

// File: rtl/wdt_interval_timer.sv
module wdt_interval_timer #(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] tick_en,
  output logic       irq_interval,
  output logic       nmi_req,
  output logic       reset_req
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [7:0]    cnt;
  logic          flag, mode, en, act, armed;
  logic [2:0]    sel;
  logic [RW-1:0] rst_cnt;
  logic [7:0]    ctrl;

  wire ctrl_wr  = bus_sel & bus_wr & ~bus_addr;
  wire cnt_wr   = bus_sel & bus_wr &  bus_addr;
  wire ctrl_rd  = bus_sel & bus_rd & ~bus_addr;
  wire stop_wr  = ctrl_wr & ~bus_wdata[5];
  wire tick     = tick_en[sel];
  wire ovf      = en & tick & (cnt == 8'hFF) & ~cnt_wr & ~stop_wr;
  wire clr      = ctrl_wr & (~bus_wdata[5] | (armed & ~bus_wdata[7]));
  wire rst_done = (rst_cnt == RW'(1));

  assign ctrl      = {flag, mode, en, 1'b1, act, sel};
  assign bus_rdata = bus_addr ? cnt : ctrl;
  assign reset_req = (rst_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || rst_done) begin
      cnt <= '0; flag <= 1'b0; mode <= 1'b0; en <= 1'b0; act <= 1'b0;
      sel <= '0; armed <= 1'b0; rst_cnt <= '0;
      irq_interval <= 1'b0; nmi_req <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode <= bus_wdata[6];
        en   <= bus_wdata[5];
        act  <= bus_wdata[3];
        sel  <= bus_wdata[2:0];
      end

      if (stop_wr || !en)  cnt <= '0;
      else if (cnt_wr)     cnt <= bus_wdata;
      else if (tick)       cnt <= cnt + 8'd1;

      if (ovf)             flag <= 1'b1;
      else if (clr)        flag <= 1'b0;

      if (clr && !ovf)               armed <= 1'b0;
      else if (ctrl_rd && flag)      armed <= 1'b1;

      irq_interval <= ovf & ~mode;
      nmi_req      <= ovf & mode & ~act;

      if (rst_cnt != '0)             rst_cnt <= rst_cnt - RW'(1);
      else if (ovf && mode && act)   rst_cnt <= RW'(RST_CYCLES);
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !cnt_wr && !stop_wr && !rst_done) |=> cnt == 8'($past(cnt) + 8'd1)); // R2
  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == 8'h00); // R3
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !rst_done) |=> flag); // R4
  AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_interval |=> !irq_interval); // R7
  AST_NMI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req); // R8
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_interval && nmi_req)); // R8
  AST_RST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> (ctrl == 8'h10 && cnt == 8'h00)); // R9
  AST_RSV_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> bus_rdata[4]); // R10
endmodule

// File: tb/test_wdt_interval_timer.sv
module test_wdt_interval_timer;
  localparam int RSTC = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, tick_en;
  logic irq_interval, nmi_req, reset_req;
  int fc = 0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  wdt_interval_timer #(.RST_CYCLES(RSTC)) i_wdt_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq_interval(irq_interval), .nmi_req(nmi_req),
    .reset_req(reset_req));

  always @(posedge clk) #1 fc <= fc + 1;
  always_comb for (int k = 0; k < 8; k++) tick_en[k] = ((fc & ((1 << k) - 1)) == 0);

  // behavioural reference
  int m_cnt, m_flag, m_mode, m_en, m_act, m_sel, m_armed, m_rst, m_irq, m_nmi;
  task automatic m_clear();
    m_cnt = 0; m_flag = 0; m_mode = 0; m_en = 0; m_act = 0; m_sel = 0;
    m_armed = 0; m_rst = 0; m_irq = 0; m_nmi = 0;
  endtask
  initial m_clear();

  always @(posedge clk) begin
    bit cw, nw, rd, tk, ov, off;
    int n_cnt, n_flag, n_armed;
    if (!rst_n || m_rst == 1) m_clear();
    else begin
      cw = bus_sel && bus_wr && !bus_addr;
      nw = bus_sel && bus_wr && bus_addr;
      rd = bus_sel && bus_rd && !bus_addr;
      tk = tick_en[m_sel];
      off = cw && !bus_wdata[5];
      n_cnt = m_cnt;
      if (off || m_en == 0) n_cnt = 0;
      else if (nw) n_cnt = bus_wdata;
      else if (tk) n_cnt = (m_cnt + 1) % 256;
      ov = m_en != 0 && tk && m_cnt == 255 && !nw && !off;
      n_flag = m_flag; n_armed = m_armed;
      if (ov) n_flag = 1;
      else if (cw && (!bus_wdata[5] || (m_armed != 0 && !bus_wdata[7]))) n_flag = 0;
      if (m_flag == 1 && n_flag == 0) n_armed = 0;
      else if (rd && m_flag == 1) n_armed = 1;
      m_irq = (ov && m_mode == 0) ? 1 : 0;
      m_nmi = (ov && m_mode == 1 && m_act == 0) ? 1 : 0;
      if (m_rst > 0) m_rst--;
      else if (ov && m_mode == 1 && m_act == 1) m_rst = RSTC;
      if (cw) begin
        m_mode = bus_wdata[6]; m_en = bus_wdata[5]; m_act = bus_wdata[3]; m_sel = bus_wdata[2:0];
      end
      m_cnt = n_cnt; m_flag = n_flag; m_armed = n_armed;
    end
  end

  function automatic int m_ctrl();
    return m_flag * 128 + m_mode * 64 + m_en * 32 + 16 + m_act * 8 + m_sel;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int irq_seen = 0, nmi_seen = 0, rst_run = 0, rst_last = 0;
  always @(negedge clk) if (rst_n) begin
    chk(bus_addr ? "R2 counter" : "R5 control", bus_rdata, bus_addr ? m_cnt : m_ctrl());
    chk("R7 irq_interval", irq_interval, m_irq);
    chk("R8 nmi_req", nmi_req, m_nmi);
    chk("R9 reset_req", reset_req, m_rst != 0);
    if (irq_interval) irq_seen++;
    if (nmi_req) nmi_seen++;
    if (reset_req) rst_run++;
    else if (rst_run != 0) begin rst_last = rst_run; rst_run = 0; end
  end

  task automatic wr_reg(bit a, logic [7:0] d);
    @(posedge clk); #1 bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask
  task automatic rd_reg(bit a, output logic [7:0] v);
    @(posedge clk); #1 bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1 bus_sel = 0; bus_rd = 0;
  endtask
  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1 bus_addr = ~bus_addr; end
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int i0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_reg(0, v); chk("R1 control after reset", v, 8'h10);
    rd_reg(1, v); chk("R1 counter after reset", v, 0);
    chk("R1 requests low", {irq_interval, nmi_req, reset_req}, 0);

    wr_reg(1, 8'h55); rd_reg(1, v); chk("R3 counter write ignored while off", v, 0);

    wr_reg(0, 8'h07); rd_reg(0, v); chk("R10 reserved bit reads 1", v, 8'h17);
    wr_reg(0, 8'h22); idle(60);
    wr_reg(0, 8'h20);
    wr_reg(1, 8'hF0); #1 bus_addr = 1; #0.5 chk("R11 counter load", bus_rdata, 8'hF0);
    i0 = irq_seen;
    idle(30);
    chk("R7 one interval pulse", irq_seen - i0, 1);
    wr_reg(0, 8'h20); rd_reg(0, v); chk("R5 clear without read ignored", v[7], 1);
    wr_reg(0, 8'hA0); rd_reg(0, v); chk("R5 writing 1 keeps flag", v[7], 1);
    wr_reg(0, 8'h20); rd_reg(0, v); chk("R5 read then write 0 clears", v[7], 0);
    chk("R4 flag was set by overflow", (irq_seen > i0) ? 1 : 0, 1);

    wr_reg(1, 8'hFC); idle(10); rd_reg(0, v); chk("R4 flag set again", v[7], 1);
    wr_reg(0, 8'h00); rd_reg(0, v); chk("R6 disable clears flag", v[7], 0);
    rd_reg(1, v); chk("R3 counter zero when off", v, 0);

    wr_reg(0, 8'h60); wr_reg(1, 8'hF8); i0 = irq_seen; nmi_seen = 0;
    idle(20);
    chk("R8 one NMI pulse", nmi_seen, 1);
    chk("R8 no interval irq", irq_seen - i0, 0);
    wr_reg(0, 8'h00);

    wr_reg(0, 8'h68); wr_reg(1, 8'hFA); idle(RSTC + 20);
    chk("R9 reset pulse length", rst_last, RSTC);
    rd_reg(0, v); chk("R9 control back to reset", v, 8'h10);
    rd_reg(1, v); chk("R9 counter back to reset", v, 0);

    wr_reg(0, 8'h23); idle(100);
    wr_reg(0, 8'h26); idle(300);
    wr_reg(0, 8'h00); idle(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule